// File: doc/BRIEF.md
# Heartbeat Window Watchdog

This block supervises a processor heartbeat arriving on a single input pin. Every level change of the heartbeat ends one pulse and starts the next one. The block measures the width of each pulse, high or low, in ticks of a slow oscillator enable. A pulse that is narrower than a lower limit or wider than an upper limit is a fault. A heartbeat that stops moving altogether is also a fault, and it is caught as soon as the count passes the upper limit, without waiting for an edge.

A fault raises a failure flag. Once the flag is up, it only drops after a fixed run of consecutive in-window pulses. A one-cycle recovered pulse marks the cycle in which it drops. A standby input holds the whole monitor idle and cleared. After reset or after standby, the first heartbeat edge only starts a fresh measurement.

The surrounding system uses the failure flag to start its own delayed reaction. It uses the recovered pulse to start the release of that reaction.

Top module: `wdw_heartbeat_monitor`

## Requirements
- R1: After reset, `fail_o` and `recovered_o` are 0 and a fresh interval measurement begins.
- R2: An interval is the number of cycles with `tick_en` high strictly between the cycle one edge is detected and the cycle the next edge is detected. An interval above `HI_TICKS` (default 80) sets `fail_o`. An interval of exactly `HI_TICKS` is good.
- R3: An interval below `LO_TICKS` (default 30) sets `fail_o`. An interval of exactly `LO_TICKS` is good.
- R4: When the running interval count reaches `HI_TICKS`+1, `fail_o` is set without waiting for an edge. The count then saturates at that value instead of wrapping.
- R5: Rising and falling edges both end an interval, so high pulses and low pulses are checked alike.
- R6: While `fail_o` is 1, the `GOOD_RUN`-th consecutive good interval (default 16) clears `fail_o`. `recovered_o` is 1 for exactly the one cycle in which `fail_o` first reads 0.
- R7: Any bad interval, or a saturated count, during recovery resets the run of good intervals to zero.
- R8: While `standby` is 1, `fail_o` is forced to 0 one cycle later and no fault can be raised. The first edge after reset or after standby produces no verdict and only restarts the measurement.
- R9: The interval count advances only in cycles where `tick_en` is 1.
- R10: `hb_in` passes through two synchronizer flops. A verdict reaches `fail_o` on the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe from the slow oscillator; interval time base |
| standby | input | 1 | Holds the monitor idle and cleared while 1 |
| hb_in | input | 1 | Asynchronous heartbeat input |
| fail_o | output | 1 | Watchdog failure flag |
| recovered_o | output | 1 | One-cycle pulse when the failure flag clears |

## Verification
A corrupted interval count appears at `fail_o` exactly three clocks after the heartbeat edge that should have been judged. The same fault also appears if the count reaches the saturation value early or late while the input is quiet. Those boundary pulse widths are where the bench samples. A wrong good-run count shows up as `fail_o` and `recovered_o` changing one or more intervals too early or too late. A missed run reset or a missed standby clear shows up within a single interval or a single cycle of the stimulus that should have cleared it.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    IV_NONE  = 2'd0,
    IV_GOOD  = 2'd1,
    IV_SHORT = 2'd2,
    IV_LONG  = 2'd3
  } iv_verdict_e;
endpackage

// File: rtl/wdw_edge_sync.sv
module wdw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb chain_d[g] = async_i;
      end else begin : g_rest
        always_comb chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdw_interval_timer.sv
module wdw_interval_timer
  import wdw_pkg::*;
#(
  parameter int LO_TICKS = 30,
  parameter int HI_TICKS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        standby_i,
  input  logic        edge_i,
  output iv_verdict_e verdict_o
);
  localparam int SAT   = HI_TICKS + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             sat;
  logic             narrow;

  assign sat    = (cnt_q == SAT_V);
  assign narrow = (cnt_q < LO_V);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (standby_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (edge_i) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (tick_en && !sat) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    verdict_o = IV_NONE;
    if (!standby_i) begin
      if (sat)                          verdict_o = IV_LONG;
      else if (edge_i && armed_q && narrow) verdict_o = IV_SHORT;
      else if (edge_i && armed_q)       verdict_o = IV_GOOD;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_V);

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !edge_i && !standby_i) |=> (cnt_q == SAT_V));

  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !edge_i && !standby_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdw_recovery.sv
module wdw_recovery
  import wdw_pkg::*;
#(
  parameter int GOOD_RUN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby_i,
  input  iv_verdict_e verdict_i,
  output logic        fail_o,
  output logic        recovered_o
);
  localparam int RUN_W = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
  localparam logic [RUN_W-1:0] LAST_V = RUN_W'(GOOD_RUN - 1);

  logic             fail_q, fail_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             rec_q, rec_d;
  logic             bad;

  assign bad = (verdict_i == IV_SHORT) || (verdict_i == IV_LONG);

  always_comb begin
    fail_d = fail_q;
    run_d  = run_q;
    rec_d  = 1'b0;
    if (standby_i) begin
      fail_d = 1'b0;
      run_d  = '0;
    end else if (bad) begin
      fail_d = 1'b1;
      run_d  = '0;
    end else if (verdict_i == IV_GOOD && fail_q) begin
      if (run_q == LAST_V) begin
        fail_d = 1'b0;
        run_d  = '0;
        rec_d  = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      run_q  <= '0;
      rec_q  <= 1'b0;
    end else begin
      fail_q <= fail_d;
      run_q  <= run_d;
      rec_q  <= rec_d;
    end
  end

  assign fail_o      = fail_q;
  assign recovered_o = rec_q;

  p_bad_sets_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !standby_i) |=> fail_q);

  p_run_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (run_q == '0));

  p_standby_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !fail_q);

  p_rec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q |-> $fell(fail_q));
endmodule

// File: rtl/wdw_heartbeat_monitor.sv
module wdw_heartbeat_monitor
  import wdw_pkg::*;
#(
  parameter int LO_TICKS    = 30,
  parameter int HI_TICKS    = 80,
  parameter int GOOD_RUN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic standby,
  input  logic hb_in,
  output logic fail_o,
  output logic recovered_o
);
  logic        hb_edge;
  iv_verdict_e verdict;

  wdw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hb_in),
    .edge_o  (hb_edge)
  );

  wdw_interval_timer #(.LO_TICKS(LO_TICKS), .HI_TICKS(HI_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .standby_i (standby),
    .edge_i    (hb_edge),
    .verdict_o (verdict)
  );

  wdw_recovery #(.GOOD_RUN(GOOD_RUN)) u_recov (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby),
    .verdict_i   (verdict),
    .fail_o      (fail_o),
    .recovered_o (recovered_o)
  );

  p_rec_only_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !standby && !recovered_o) |=> (fail_o || standby || recovered_o) || $past(standby));
endmodule

// File: tb/wdw_heartbeat_monitor_bench.sv
module wdw_heartbeat_monitor_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    due;
    logic  f;
    logic  r;
    string tag;
  } exp_t;

  logic clk, rst_n, tick_en, standby, hb_in;
  logic fail_o, recovered_o;

  int   cyc = 0;
  int   last_t = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];

  wdw_heartbeat_monitor u_wdw_heartbeat_monitor (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .standby(standby),
    .hb_in(hb_in), .fail_o(fail_o), .recovered_o(recovered_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic got_f, input logic got_r, input exp_t e);
    total++;
    if (got_f !== e.f || got_r !== e.r) begin
      bad++;
      $display("FAIL %s cyc=%0d fail/rec actual=%b/%b expected=%b/%b",
               e.tag, cyc, got_f, got_r, e.f, e.r);
    end
  endtask

  // monitor: pops expectations when due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        e.tag = {e.tag, " (missed)"};
        chk(1'bx, 1'bx, e);
      end else begin
        chk(fail_o, recovered_o, e);
      end
    end
  end

  // driver helpers
  task automatic expect_at(input int ofs, input logic f, input logic r, input string tag);
    exp_t e;
    e.due = last_t + ofs; e.f = f; e.r = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic gap(input int d);
    repeat (d) @(negedge clk);
    hb_in = ~hb_in;
    last_t = cyc;
  endtask

  task automatic recover(input string tag);
    for (int i = 1; i <= 16; i++) begin
      gap(50);
      if (i == 15) expect_at(3, 1'b1, 1'b0, {tag, " R6 still failed at 15"});
      if (i == 16) begin
        expect_at(2, 1'b1, 1'b0, {tag, " R10 before clear"});
        expect_at(3, 1'b0, 1'b1, {tag, " R6 clear with pulse"});
        expect_at(4, 1'b0, 1'b0, {tag, " R6 pulse one cycle"});
      end
    end
  endtask

  task automatic align(input logic lvl);
    if (hb_in !== lvl) begin
      gap(50);
      expect_at(3, 1'b0, 1'b0, "align good");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    rst_n = 1'b0; tick_en = 1'b1; standby = 1'b0; hb_in = 1'b0;
    repeat (5) @(negedge clk);
    e0.due = cyc; e0.f = 1'b0; e0.r = 1'b0; e0.tag = "R1 reset state";
    chk(fail_o, recovered_o, e0);

    // R1/R4: no edge after reset -> saturation failure
    rst_n = 1'b1; last_t = cyc;
    expect_at(81, 1'b0, 1'b0, "R1 R4 quiet before limit");
    expect_at(82, 1'b1, 1'b0, "R4 no edge fails");
    repeat (90) @(negedge clk);

    // first edge arms, then a run of 16 clears
    gap(10);
    expect_at(3, 1'b1, 1'b0, "R4 saturated still failed");
    recover("R6 first");

    // R3/R5: short high pulse, short low pulse
    align(1'b1);
    gap(20);
    expect_at(2, 1'b0, 1'b0, "R10 latency before");
    expect_at(3, 1'b1, 1'b0, "R3 R5 short high pulse");
    recover("after high");
    align(1'b0);
    gap(20);
    expect_at(3, 1'b1, 1'b0, "R5 short low pulse");
    recover("after low");

    // R3 boundaries
    gap(31); expect_at(3, 1'b0, 1'b0, "R3 exactly LO good");
    gap(30); expect_at(3, 1'b1, 1'b0, "R3 LO-1 short");
    recover("after LO");

    // R2 boundaries
    gap(81); expect_at(3, 1'b0, 1'b0, "R2 exactly HI good");
    gap(82);
    expect_at(2, 1'b0, 1'b0, "R2 before verdict");
    expect_at(3, 1'b1, 1'b0, "R2 HI+1 long");
    recover("after HI");

    // R4 mid-run missing edge
    expect_at(84, 1'b0, 1'b0, "R4 quiet at limit");
    expect_at(85, 1'b1, 1'b0, "R4 saturation fails without edge");
    repeat (90) @(negedge clk);
    gap(50); expect_at(3, 1'b1, 1'b0, "R4 edge after saturation bad");
    recover("after sat");

    // R7: a short during recovery restarts the run
    gap(20); expect_at(3, 1'b1, 1'b0, "R7 initial short");
    for (int i = 0; i < 10; i++) gap(50);
    gap(20); expect_at(3, 1'b1, 1'b0, "R7 short mid-run");
    recover("R7 restart");

    // R8: standby clears and holds
    gap(20); expect_at(3, 1'b1, 1'b0, "R8 pre-standby fail");
    repeat (5) @(negedge clk);
    standby = 1'b1; last_t = cyc;
    expect_at(1, 1'b0, 1'b0, "R8 standby clears");
    for (int i = 0; i < 3; i++) begin
      gap(20); expect_at(3, 1'b0, 1'b0, "R8 edges ignored in standby");
    end
    repeat (150) @(negedge clk);
    standby = 1'b0;
    gap(5); expect_at(3, 1'b0, 1'b0, "R8 first edge only arms");
    gap(50); expect_at(3, 1'b0, 1'b0, "R8 measuring after standby");

    // R9: tick gating freezes the count
    gap(50); expect_at(3, 1'b0, 1'b0, "R9 pre-gate good");
    tick_en = 1'b0;
    expect_at(150, 1'b0, 1'b0, "R9 gated no saturation");
    expect_at(299, 1'b0, 1'b0, "R9 gated still quiet");
    repeat (300) @(negedge clk);
    tick_en = 1'b1;
    gap(40); expect_at(3, 1'b0, 1'b0, "R9 only enabled ticks counted");
    gap(20); expect_at(3, 1'b1, 1'b0, "R9 ticking resumed short");

    repeat (10) @(negedge clk);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL pending expectations actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule